// File: doc/BRIEF.md
# Memory buffer control-word sequencer

This block programs the control words of a load-reduced memory buffer through a narrow command port. A single start pulse launches a fixed sequence of 58 writes. The sequence is a fixed programming table followed by three loops whose addresses are generated in hardware: data-lane termination, on-die-termination per function, and personality bytes. Every write takes two strobes on the command port. The first strobe selects the buffer function by writing the function number into the reserved word 7. The second strobe writes a 4-bit value into the target word.

A value comes from one of three places. It can be a literal held in the table. It can be a masked nibble of a configuration-byte array, which is a copy of the module's serial presence data. It can also be a nibble from an external calculator, supplied on `special_vals`. The speed grade selects which block of speed-dependent configuration bytes the termination loops read. Guard gaps and the clock-stabilization pause are counted in clock cycles derived from the `CLK_MHZ` parameter, so the strobe spacing is exact and predictable.

Configuration byte i sits at `cfg_bytes[8*i+7:8*i]`. Special slot j sits at `special_vals[4*j+3:4*j]`.

Top module: `mb_ctlword_seq`

## Requirements
- R1: Every write produces two strobes on `cmd_stb`. The first carries `cmd_word`=7 and `cmd_data`=function number. The second carries the target word and value. Word 7 is never a target. Strobes occur only while `busy` is high.
- R2: Consecutive strobes are exactly G = CLK_MHZ*8000/1000 cycles apart, and the first strobe comes G cycles after the edge that samples `start`. This is an 8 µs guard before every select strobe and before every data strobe.
- R3: The table issues these writes in this order as (function, word, value): (0,0,0), (0,1,0), (0,2,byte0&0x03), (0,10,slot0), (1,8,byte1&0x0F), (1,11,(byte1&0xF0)>>4), pause, (0,3,(byte2&0xF0)>>4), (0,9,0xC), (0,13,slot1), (3,2,1).
- R4: For an entry taken from a configuration byte, the byte is ANDed with the entry's mask. If the mask has bits in its upper nibble, the result is shifted right by 4. Otherwise the low nibble is used as it is.
- R5: The pause entry issues no strobe. It lengthens the gap between the strobe before it and the strobe after it to G + P cycles, where P = CLK_MHZ*6000/1000.
- R6: The speed set is ((speed_mhz/133)−3)/2, using integer division, and the byte offset is set×6. Speeds 400 and 533 use set 0. Speeds 667 and 800 use set 1.
- R7: After the table, the block writes function 3, word 8 with the low nibble of byte 4+offset, masked to 3 bits. It then writes function 3, word 9 with the high nibble of the same byte, masked to 3 bits.
- R8: Next come functions 3 to 10 in rising order, each with word 10 and then word 11. Both words use byte 5+offset+((fn−3)>>1). Word 10 takes the low nibble and word 11 the high nibble. Even functions write bits 3:2 of that nibble and odd functions write bits 1:0.
- R9: Last come functions 14 and then 15, words 0 to 15 in rising order with word 7 skipped. Word w uses byte 16+8*(fn−14)+(w>>1). Odd words take the high nibble and even words the low nibble. Function 14, word 0 has bit 0 forced to 1.
- R10: `done` pulses high for exactly one cycle, one cycle after the last data strobe. `busy` falls in that same cycle.
- R11: A start pulse that arrives while `busy` is high is ignored. The running sequence keeps its contents and its timing.
- R12: Synchronous reset clears `busy`, `done` and `cmd_stb`. This holds during a run as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the sequence when idle |
| speed_mhz | input | 10 | Memory speed grade in MT/s-style units (400..800) |
| cfg_bytes | input | 256 | Configuration-byte array, byte i at bits 8i+7:8i |
| special_vals | input | 8 | Externally computed nibbles, slot j at bits 4j+3:4j |
| cmd_stb | output | 1 | One-cycle command write strobe |
| cmd_word | output | 4 | Control word number for the strobe |
| cmd_data | output | 4 | Value for the strobe |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle completion pulse |

## Verification
A step pointer that slips or repeats shows up at the ports straight away. The next data strobe carries the wrong word or function, or the select and data strobes stop alternating, and each of these is caught at the strobe where it happens. A timer that is loaded wrongly moves that strobe off its expected cycle, and every later strobe moves with it. An error in byte-offset or nibble selection shows up only in the loop that uses it. For that reason every speed set, both nibble halves and both function parities are compared strobe by strobe against a model built from the requirements.

// File: rtl/mbcw_pkg.sv
package mbcw_pkg;

  typedef enum logic [1:0] {SRC_LIT, SRC_CFG, SRC_SPC, SRC_PAUSE} src_e;

  typedef struct packed {
    logic [3:0] fn;
    logic [3:0] word;
    src_e       src;
    logic [4:0] bidx;
    logic [7:0] mask;   // mask for SRC_CFG, literal for SRC_LIT, slot for SRC_SPC
  } tbl_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_GAP1, ST_SEL, ST_GAP2, ST_WR, ST_PAUSE, ST_FIN
  } seq_st_e;

  localparam int         TBL_LEN  = 11;
  localparam logic [3:0] SEL_WORD = 4'd7;

  function automatic tbl_ent_t mk(input logic [3:0] fn, input logic [3:0] word,
                                  input src_e src, input logic [4:0] bidx,
                                  input logic [7:0] mask);
    tbl_ent_t e;
    e.fn = fn; e.word = word; e.src = src; e.bidx = bidx; e.mask = mask;
    return e;
  endfunction

  function automatic tbl_ent_t tbl_lookup(input logic [3:0] idx);
    case (idx)
      4'd0:    return mk(4'd0, 4'd0,  SRC_LIT,   5'd0, 8'h00);
      4'd1:    return mk(4'd0, 4'd1,  SRC_LIT,   5'd0, 8'h00);
      4'd2:    return mk(4'd0, 4'd2,  SRC_CFG,   5'd0, 8'h03);
      4'd3:    return mk(4'd0, 4'd10, SRC_SPC,   5'd0, 8'h00);
      4'd4:    return mk(4'd1, 4'd8,  SRC_CFG,   5'd1, 8'h0F);
      4'd5:    return mk(4'd1, 4'd11, SRC_CFG,   5'd1, 8'hF0);
      4'd6:    return mk(4'd0, 4'd0,  SRC_PAUSE, 5'd0, 8'h00);
      4'd7:    return mk(4'd0, 4'd3,  SRC_CFG,   5'd2, 8'hF0);
      4'd8:    return mk(4'd0, 4'd9,  SRC_LIT,   5'd0, 8'h0C);
      4'd9:    return mk(4'd0, 4'd13, SRC_SPC,   5'd0, 8'h01);
      4'd10:   return mk(4'd3, 4'd2,  SRC_LIT,   5'd0, 8'h01);
      default: return mk(4'd0, 4'd0,  SRC_LIT,   5'd0, 8'h00);
    endcase
  endfunction

endpackage

// File: rtl/mbcw_timer.sv
module mbcw_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mbcw_step_decode.sv
module mbcw_step_decode
  import mbcw_pkg::*;
#(
  parameter int CFG_BYTES = 32,
  parameter int SPC_SLOTS = 2,
  parameter int MDQ_BASE  = 4,
  parameter int ODT_BASE  = 5,
  parameter int PERS_BASE = 16,
  parameter int STEP_W    = 6,
  parameter int BI_W      = 5
) (
  input  logic [STEP_W-1:0]      step,
  input  logic [BI_W-1:0]        byte_off,
  input  logic [CFG_BYTES*8-1:0] cfg,
  input  logic [SPC_SLOTS*4-1:0] spc,
  output logic                   is_pause,
  output logic [3:0]             fn,
  output logic [3:0]             word,
  output logic [3:0]             val
);
  localparam int MDQ_START  = TBL_LEN;
  localparam int ODT_START  = MDQ_START + 2;
  localparam int PERS_START = ODT_START + 16;

  always_comb begin
    int s, k, r, w, bi;
    logic [7:0] b;
    logic [3:0] nib;
    tbl_ent_t e;
    s = int'(step);
    k = 0; r = 0; w = 0; bi = 0;
    b = '0; nib = '0; e = '0;
    is_pause = 1'b0; fn = '0; word = '0; val = '0;
    if (s < MDQ_START) begin
      // fixed table
      e = tbl_lookup(4'(s));
      fn = e.fn;
      word = e.word;
      case (e.src)
        SRC_PAUSE: is_pause = 1'b1;
        SRC_LIT:   val = e.mask[3:0];
        SRC_SPC:   val = spc[int'(e.mask[3:0])*4 +: 4];
        default: begin
          b = cfg[int'(e.bidx)*8 +: 8] & e.mask;
          val = (e.mask[7:4] != 4'd0) ? b[7:4] : b[3:0];
        end
      endcase
    end else if (s < ODT_START) begin
      // data-lane termination: one byte, two 3-bit fields
      k = s - MDQ_START;
      fn = 4'd3;
      word = 4'(8 + k);
      bi = MDQ_BASE + int'(byte_off);
      b = cfg[bi*8 +: 8];
      nib = (k == 0) ? b[3:0] : b[7:4];
      val = {1'b0, nib[2:0]};
    end else if (s < PERS_START) begin
      // termination per function: two functions share a byte
      k = s - ODT_START;
      fn = 4'(3 + k / 2);
      word = 4'(10 + k % 2);
      bi = ODT_BASE + int'(byte_off) + k / 4;
      b = cfg[bi*8 +: 8];
      nib = (k % 2 == 1) ? b[7:4] : b[3:0];
      val = fn[0] ? {2'b00, nib[1:0]} : {2'b00, nib[3:2]};
    end else begin
      // personality nibbles, select word skipped
      k = s - PERS_START;
      r = (k < 15) ? k : k - 15;
      w = (r >= 7) ? r + 1 : r;
      fn = (k < 15) ? 4'd14 : 4'd15;
      word = 4'(w);
      bi = PERS_BASE + ((k < 15) ? 0 : 8) + w / 2;
      b = cfg[bi*8 +: 8];
      if (k == 0) b[0] = 1'b1;
      val = (w % 2 == 1) ? b[7:4] : b[3:0];
    end
  end
endmodule

// File: rtl/mb_ctlword_seq.sv
module mb_ctlword_seq
  import mbcw_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int GUARD_NS    = 8000,
  parameter int PAUSE_NS    = 6000,
  parameter int SPEED_W     = 10,
  parameter int CFG_BYTES   = 32,
  parameter int SPC_SLOTS   = 2,
  parameter int FREQ_STRIDE = 6,
  parameter int MDQ_BASE    = 4,
  parameter int ODT_BASE    = 5,
  parameter int PERS_BASE   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [SPEED_W-1:0]     speed_mhz,
  input  logic [CFG_BYTES*8-1:0] cfg_bytes,
  input  logic [SPC_SLOTS*4-1:0] special_vals,
  output logic                   cmd_stb,
  output logic [3:0]             cmd_word,
  output logic [3:0]             cmd_data,
  output logic                   busy,
  output logic                   done
);
  localparam int GUARD_CYC = CLK_MHZ * GUARD_NS / 1000;
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_NS / 1000;
  localparam int N_STEPS   = TBL_LEN + 2 + 16 + 30;
  localparam int STEP_W    = $clog2(N_STEPS);
  localparam int BI_W      = $clog2(CFG_BYTES);
  localparam int MAX_CYC   = (GUARD_CYC > PAUSE_CYC) ? GUARD_CYC : PAUSE_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  seq_st_e           st;
  logic [STEP_W-1:0] step;
  logic [BI_W-1:0]   byte_off, off_calc;
  logic              dec_pause, tmr_load, tmr_zero;
  logic [3:0]        dec_fn, dec_word, dec_val;
  logic [CNT_W-1:0]  tmr_val;
  logic [31:0]       guard_len_w;

  assign guard_len_w = 32'(GUARD_CYC);

  always_comb begin
    int q;
    q = int'(speed_mhz) / 133;
    if (q < 3) q = 3;
    off_calc = BI_W'(((q - 3) / 2) * FREQ_STRIDE);
  end

  mbcw_step_decode #(
    .CFG_BYTES(CFG_BYTES), .SPC_SLOTS(SPC_SLOTS), .MDQ_BASE(MDQ_BASE),
    .ODT_BASE(ODT_BASE), .PERS_BASE(PERS_BASE), .STEP_W(STEP_W), .BI_W(BI_W)
  ) u_dec (
    .step(step), .byte_off(byte_off), .cfg(cfg_bytes), .spc(special_vals),
    .is_pause(dec_pause), .fn(dec_fn), .word(dec_word), .val(dec_val)
  );

  // Timer loads are trimmed so that strobe-to-strobe spacing is exact.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st == ST_ARM) begin
      tmr_load = 1'b1;
      tmr_val  = dec_pause ? CNT_W'(PAUSE_CYC - 2) : CNT_W'(GUARD_CYC - 3);
    end else if (st == ST_SEL) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(GUARD_CYC - 2);
    end
  end

  mbcw_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      step     <= '0;
      byte_off <= '0;
      cmd_stb  <= 1'b0;
      cmd_word <= '0;
      cmd_data <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      cmd_stb <= 1'b0;
      done    <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          busy     <= 1'b1;
          step     <= '0;
          byte_off <= off_calc;
          st       <= ST_ARM;
        end
        ST_ARM:   st <= dec_pause ? ST_PAUSE : ST_GAP1;
        ST_GAP1:  if (tmr_zero) st <= ST_SEL;
        ST_SEL: begin
          cmd_stb  <= 1'b1;
          cmd_word <= SEL_WORD;
          cmd_data <= dec_fn;
          st       <= ST_GAP2;
        end
        ST_GAP2:  if (tmr_zero) st <= ST_WR;
        ST_WR: begin
          cmd_stb  <= 1'b1;
          cmd_word <= dec_word;
          cmd_data <= dec_val;
          if (step == LAST_STEP) st <= ST_FIN;
          else begin
            step <= step + 1'b1;
            st   <= ST_ARM;
          end
        end
        ST_PAUSE: if (tmr_zero) begin
          step <= step + 1'b1;
          st   <= ST_ARM;
        end
        default: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/mbcw_chk.sv
module mbcw_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        cmd_stb,
  input logic [3:0]  cmd_word,
  input logic [31:0] guard_len
);
  logic        exp_sel, seen;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_sel <= 1'b1;
      seen    <= 1'b0;
      gap     <= '0;
    end else if (cmd_stb) begin
      exp_sel <= ~exp_sel;
      seen    <= 1'b1;
      gap     <= '0;
    end else begin
      if (gap != 32'hFFFF_FFFF) gap <= gap + 1;
      if (!busy) seen <= 1'b0;
    end
  end

  // R1
  sel_alt_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> ((cmd_word == 4'd7) == exp_sel));

  // R1
  stb_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> busy);

  // R2
  gap_min_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && seen) |-> (gap >= guard_len - 1));

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind mb_ctlword_seq mbcw_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .cmd_stb(cmd_stb), .cmd_word(cmd_word), .guard_len(guard_len_w)
);

// File: tb/mb_ctlword_seq_tb.sv
module mb_ctlword_seq_tb;
  localparam int CLK_MHZ = 1;             // scales the cycle counts only
  localparam int G = CLK_MHZ * 8000 / 1000;
  localparam int P = CLK_MHZ * 6000 / 1000;
  localparam int NV = 4;
  localparam logic [9:0] V_SPD  [NV] = '{10'd400, 10'd533, 10'd667, 10'd800};
  localparam logic [7:0] V_SEED [NV] = '{8'h11, 8'hA7, 8'h3C, 8'hF2};
  localparam logic [7:0] V_SPC  [NV] = '{8'h5A, 8'h0F, 8'hE1, 8'h96};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [9:0] speed_mhz = 10'd400;
  logic [255:0] cfg_bytes = '0;
  logic [7:0] special_vals = '0;
  logic cmd_stb, busy, done;
  logic [3:0] cmd_word, cmd_data;

  always #2 clk = ~clk;   // 250 MHz

  mb_ctlword_seq #(.CLK_MHZ(CLK_MHZ)) u_dut (
    .clk(clk), .rst(rst), .start(start), .speed_mhz(speed_mhz),
    .cfg_bytes(cfg_bytes), .special_vals(special_vals), .cmd_stb(cmd_stb),
    .cmd_word(cmd_word), .cmd_data(cmd_data), .busy(busy), .done(done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] cb [32];
  logic [3:0] e_word [256], e_data [256], c_word [256], c_data [256];
  int e_time [256], c_time [256];
  string e_tag [256], e_ttag [256];
  int n_exp, n_cap, d_cnt, d_time, t_acc, pend;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && cmd_stb && n_cap < 256) begin
      c_word[n_cap] = cmd_word; c_data[n_cap] = cmd_data; c_time[n_cap] = cyc;
      n_cap++;
    end
    if (!rst && done) begin d_cnt++; d_time = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] w, input logic [3:0] d, input string tag,
                      input string ttag);
    e_word[n_exp] = w; e_data[n_exp] = d; e_time[n_exp] = t_acc;
    e_tag[n_exp] = tag; e_ttag[n_exp] = ttag;
    n_exp++;
  endtask

  // R1: select strobe then data strobe; R2/R5: spacing
  task automatic add_wr(input int fn, input int w, input int v, input string tag);
    string tt;
    tt = (pend != 0) ? "R5 gap" : "R2 gap";
    t_acc += G + pend; pend = 0;
    push(4'd7, 4'(fn), "R1 select", tt);
    t_acc += G;
    push(4'(w), 4'(v), tag, "R2 gap");
  endtask

  task automatic build_exp(input int spd, input logic [7:0] spc, input int t0);
    int set, o;
    logic [7:0] b;
    logic [3:0] nib;
    n_exp = 0; t_acc = t0; pend = 0;
    add_wr(0, 0, 0, "R3");
    add_wr(0, 1, 0, "R3");
    add_wr(0, 2, int'(cb[0] & 8'h03), "R4 low");
    add_wr(0, 10, int'(spc[3:0]), "R3 slot0");
    add_wr(1, 8, int'(cb[1][3:0]), "R4 low");
    add_wr(1, 11, int'(cb[1][7:4]), "R4 high");
    pend = P;   // R5 pause entry
    add_wr(0, 3, int'(cb[2][7:4]), "R4 high");
    add_wr(0, 9, 12, "R3");
    add_wr(0, 13, int'(spc[7:4]), "R3 slot1");
    add_wr(3, 2, 1, "R3");
    set = ((spd / 133) - 3) / 2;   // R6
    o = set * 6;
    b = cb[4 + o];
    add_wr(3, 8, int'(b[2:0]), "R7 R6");
    add_wr(3, 9, int'(b[6:4]), "R7 R6");
    for (int fn = 3; fn <= 10; fn++)
      for (int w = 10; w <= 11; w++) begin
        b = cb[5 + o + (fn - 3) / 2];
        nib = (w == 11) ? b[7:4] : b[3:0];
        add_wr(fn, w, (fn % 2 == 0) ? int'(nib[3:2]) : int'(nib[1:0]), "R8 R6");
      end
    for (int fn = 14; fn <= 15; fn++)
      for (int w = 0; w <= 15; w++) begin
        if (w != 7) begin
          b = cb[16 + 8 * (fn - 14) + w / 2];
          if (fn == 14 && w == 0) b[0] = 1'b1;
          add_wr(fn, w, (w % 2 == 1) ? int'(b[7:4]) : int'(b[3:0]), "R9");
        end
      end
  endtask

  task automatic run_vec(input logic [9:0] spd, input logic [7:0] seed,
                         input logic [7:0] spc, input bit inject);
    int t0, k;
    for (int i = 0; i < 32; i++) begin
      cb[i] = 8'(int'(seed) * 7 + i * 53 + 3);
      cfg_bytes[i*8 +: 8] = cb[i];
    end
    speed_mhz = spd; special_vals = spc;
    n_cap = 0; d_cnt = 0; d_time = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin t0 = cyc; start = 1'b0; end
    build_exp(int'(spd), spc, t0);
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b1, "R11 busy kept", int'(busy), 1);
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    k = 0;
    while (d_cnt == 0 && k < 5000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    chk(n_cap == n_exp, inject ? "R11 strobe count" : "R1 strobe count", n_cap, n_exp);
    for (int i = 0; i < n_exp; i++) begin
      if (i < n_cap) begin
        chk(c_word[i] == e_word[i], e_tag[i], int'(c_word[i]), int'(e_word[i]));
        chk(c_data[i] == e_data[i], e_tag[i], int'(c_data[i]), int'(e_data[i]));
        chk(c_time[i] == e_time[i], e_ttag[i], c_time[i] - t0, e_time[i] - t0);
      end
    end
    chk(d_cnt == 1, "R10 done pulses", d_cnt, 1);
    chk(d_time == e_time[n_exp-1] + 1, "R10 done cycle", d_time - t0, e_time[n_exp-1] + 1 - t0);
    chk(busy == 1'b0, "R10 busy low", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(busy == 1'b0, "R12 busy", int'(busy), 0);
    chk(done == 1'b0, "R12 done", int'(done), 0);
    chk(cmd_stb == 1'b0, "R12 stb", int'(cmd_stb), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R12 idle after reset", int'(busy), 0);

    for (int v = 0; v < NV; v++) run_vec(V_SPD[v], V_SEED[v], V_SPC[v], 1'b0);

    // R11: start pulses while running are ignored
    run_vec(10'd667, 8'h00, 8'hFF, 1'b1);

    // R12: reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R12 mid-run busy", int'(busy), 0);
    chk(cmd_stb == 1'b0, "R12 mid-run stb", int'(cmd_stb), 0);
    rst = 1'b0;
    n_cap = 0;
    repeat (3 * G) @(negedge clk);
    chk(n_cap == 0, "R12 quiet after reset", n_cap, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule